// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Wake-Event Line Controller

This block watches a set of request lines: sixteen that come from general-purpose pins and three from on-chip sources (a supply-voltage monitor, a real-time-clock alarm and a bus wake-up detector). Every line is first retimed into the local clock domain. A rising edge, a falling edge or either of the two can then mark the line as requesting. A request sets a pending bit for that line. The pending bit feeds an interrupt output for that line through an interrupt mask. A separate event mask turns the same request into a one-clock wake-up pulse, without any need for an interrupt.

Software reaches the controller through a register port with a single-cycle write strobe and a combinational read mux. Software can also inject a request on any line by writing a trigger register. A request is acknowledged by writing a 1 to that line's pending bit. The same write also releases the software trigger bit of that line.

Top module: `exti_lines`

## Requirements
- R1: After a change on `line_in` is captured at a clock edge, its effect on pending state and on `evt_o` becomes visible after the second edge that follows that capture, and not before.
- R2: When a line's bit in the rising-select register (address 0) is 1, a 0-to-1 transition on that line sets its pending bit. The pending register is read at address 5, with bit i holding line i.
- R3: When a line's bit in the falling-select register (address 1) is 1, a 1-to-0 transition sets its pending bit. A line with both select bits set requests on both of its edges.
- R4: A transition on a line whose two select bits are both 0 leaves every pending bit and `evt_o` unchanged.
- R5: `irq_o[i]` is 1 exactly while pending bit i is 1 and bit i of the interrupt-mask register (address 2) is 1.
- R6: `evt_o` goes high for one clock, in the cycle in which the pending bit would be set, when at least one requesting line has its bit in the event-mask register (address 3) set. Pending bits are set whatever the two masks hold.
- R7: Writing 1 to a bit of the software-trigger register (address 4) while that bit is 0 sets the bit and raises a request on that line at the write edge. Writing 1 to a bit that is already set raises no new request.
- R8: Writing 1 to a bit at address 5 clears that pending bit and the software-trigger bit of the same line. Writing 0 to a bit leaves it unchanged.
- R9: When a new request arrives on a line at the same edge as a clear of that line, the pending bit ends up set.
- R10: During reset and right after it, all registers read 0, `irq_o` is 0 and `evt_o` is 0. Addresses 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NLINES | Raw request lines, asynchronous to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register address |
| wdata | input | NLINES | Write data, one bit per line |
| rdata | output | NLINES | Read data for `addr` (combinational) |
| irq_o | output | NLINES | Per-line interrupt requests |
| evt_o | output | 1 | One-clock wake-up event pulse |

## Verification
The bench builds the controller with its defaults: 19 lines and a two-stage synchronizer. With these values the three internal-source lines (16 to 18) sit at the top of the vector, next to the pin lines, so a mistake in the top bits or in a width shows up. The two-stage latency is short enough that directed checks can sample the exact edge at which a pending bit appears. A lookahead model steps through the same cycles as the design and compares `irq_o`, `evt_o` and the read data of every address on every clock. Random toggling with random masks drives simultaneous edges on several lines, requests that collide with clears, and repeated software triggers.

// File: rtl/exti_lines.sv
module exti_lines #(
  parameter int NLINES = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] rdata,
  output logic [NLINES-1:0] irq_o,
  output logic              evt_o
);
  localparam logic [2:0] A_RISE = 3'd0;
  localparam logic [2:0] A_FALL = 3'd1;
  localparam logic [2:0] A_IMSK = 3'd2;
  localparam logic [2:0] A_EMSK = 3'd3;
  localparam logic [2:0] A_SWT  = 3'd4;
  localparam logic [2:0] A_PEND = 3'd5;

  logic [NLINES-1:0] sync_q [SYNC_STAGES];
  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] rise_q, fall_q, imsk_q, emsk_q, swt_q, pend_q;
  logic [NLINES-1:0] cur, hit, sw_req, clr, req;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= line_in;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign hit    = (cur & ~prev_q & rise_q) | (~cur & prev_q & fall_q);
  assign sw_req = (wr_en && addr == A_SWT) ? (wdata & ~swt_q) : '0;
  assign clr    = (wr_en && addr == A_PEND) ? wdata : '0;
  assign req    = hit | sw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      imsk_q <= '0;
      emsk_q <= '0;
      swt_q  <= '0;
      pend_q <= '0;
      evt_o  <= 1'b0;
    end else begin
      prev_q <= cur;
      pend_q <= (pend_q & ~clr) | req;
      swt_q  <= (swt_q | sw_req) & ~clr;
      evt_o  <= |(req & emsk_q);
      if (wr_en) begin
        case (addr)
          A_RISE:  rise_q <= wdata;
          A_FALL:  fall_q <= wdata;
          A_IMSK:  imsk_q <= wdata;
          A_EMSK:  emsk_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = pend_q & imsk_q;

  always_comb begin
    case (addr)
      A_RISE:  rdata = rise_q;
      A_FALL:  rdata = fall_q;
      A_IMSK:  rdata = imsk_q;
      A_EMSK:  rdata = emsk_q;
      A_SWT:   rdata = swt_q;
      A_PEND:  rdata = pend_q;
      default: rdata = '0;
    endcase
  end
endmodule

module exti_lines_chk #(
  parameter int NLINES = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [NLINES-1:0] wdata,
  input logic [NLINES-1:0] irq_o,
  input logic              evt_o,
  input logic [NLINES-1:0] emsk_q,
  input logic [NLINES-1:0] swt_q,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] req
);
  // R6
  evt_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ($past(emsk_q) != '0));

  // R2
  pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |-> ($past(req) != '0));

  // R7
  swt_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((swt_q & ~$past(swt_q)) != '0) |-> $past(wr_en && addr == 3'd4));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd5) |-> ((pend_q & $past(wdata & ~req)) == '0));

  // R5
  irq_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> (pend_q != '0));
endmodule

bind exti_lines exti_lines_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_o(irq_o), .evt_o(evt_o), .emsk_q(emsk_q), .swt_q(swt_q),
  .pend_q(pend_q), .req(req)
);

// File: tb/tb_exti_lines.sv
module tb_exti_lines;
  localparam int N = 19;
  localparam time CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, irq_o;
  logic evt_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  exti_lines dut (.clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .evt_o(evt_o));

  always #(CLK_P/2) clk = ~clk;

  // reference model: regs[0..5] by address, hist = samples (newest first)
  logic [N-1:0] m_reg [6];
  logic [N-1:0] hist [$];
  logic m_evt;

  initial begin
    for (int i = 0; i < 6; i++) m_reg[i] = '0;
    hist = '{'0, '0, '0};
    m_evt = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_reg[i] = '0;
      hist = '{'0, '0, '0};
      m_evt = 1'b0;
    end else begin
      logic [N-1:0] now_v, old_v, edges, swr, clrv, reqs;
      now_v = hist[1];
      old_v = hist[2];
      edges = (now_v & ~old_v & m_reg[0]) | (~now_v & old_v & m_reg[1]);
      swr = '0; clrv = '0;
      if (wr_en && addr == 3'd4) swr = wdata & ~m_reg[4];
      if (wr_en && addr == 3'd5) clrv = wdata;
      reqs = edges | swr;
      m_evt = (reqs & m_reg[3]) != '0;
      m_reg[5] = (m_reg[5] & ~clrv) | reqs;
      m_reg[4] = (m_reg[4] | swr) & ~clrv;
      if (wr_en && addr < 3'd4) m_reg[addr] = wdata;
      hist.push_front(line_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] exp_rd;
    cycles++;
    exp_rd = (addr < 3'd6) ? m_reg[addr] : '0;
    chk(rdata === exp_rd, "R10/R2 rdata", rdata, exp_rd);
    chk(irq_o === (m_reg[5] & m_reg[2]), "R5 irq", irq_o, m_reg[5] & m_reg[2]);
    chk(evt_o === m_evt, "R6 evt", {{(N-1){1'b0}}, evt_o}, {{(N-1){1'b0}}, m_evt});
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    addr = a; #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    step();
    rd(3'd5, '0, "R10 reset pending");
    chk(irq_o === '0 && evt_o === 1'b0, "R10 reset outputs", irq_o, '0);
    step(); rst_n = 1'b1; step();
    rd(3'd0, '0, "R10 rise after reset");
    rd(3'd6, '0, "R10 unused address");

    wr(3'd0, 19'h0_0008);
    wr(3'd2, 19'h0_0008);
    wr(3'd3, 19'h0_0008);
    line_in[3] = 1'b1;
    step(); step();
    rd(3'd5, '0, "R1 not yet after two edges");
    step();
    rd(3'd5, 19'h0_0008, "R1 R2 pending after third edge");
    chk(irq_o === 19'h0_0008, "R5 irq line3", irq_o, 19'h0_0008);
    wr(3'd5, '0);
    rd(3'd5, 19'h0_0008, "R8 write zero keeps");
    wr(3'd5, 19'h0_0008);
    rd(3'd5, '0, "R8 write one clears");

    wr(3'd1, 19'h5_0000);
    wr(3'd0, 19'h4_0008);
    line_in[16] = 1'b1; line_in[18] = 1'b1; line_in[5] = 1'b1;
    repeat (4) step();
    rd(3'd5, 19'h4_0000, "R3 R4 rising on both-select line only");
    line_in[16] = 1'b0; line_in[18] = 1'b0; line_in[5] = 1'b0;
    repeat (4) step();
    rd(3'd5, 19'h5_0000, "R3 falling on 16 and 18, R4 line5 ignored");
    wr(3'd5, 19'h7_FFFF);

    wr(3'd4, 19'h2_0000);
    rd(3'd5, 19'h2_0000, "R7 software request");
    wr(3'd5, 19'h2_0000);
    wr(3'd4, 19'h2_0000);
    rd(3'd4, 19'h2_0000, "R7 trigger set again");
    wr(3'd5, 19'h2_0000);
    rd(3'd4, '0, "R8 clears trigger");
    wr(3'd4, 19'h2_0000);
    wr(3'd4, 19'h2_0000);
    rd(3'd5, 19'h2_0000, "R7 resend no new request");
    wr(3'd5, 19'h2_0000);
    wr(3'd5, 19'h2_0000);
    rd(3'd5, '0, "R7 stays clear");

    line_in[3] = 1'b0; repeat (3) step();
    line_in[3] = 1'b1; step(); step();
    wr(3'd5, 19'h0_0008);
    rd(3'd5, 19'h0_0008, "R9 set wins over clear");
    wr(3'd5, 19'h7_FFFF);

    for (int n = 0; n < 3000; n++) begin
      line_in = line_in ^ (N'($urandom) & N'($urandom));
      if ($urandom_range(0, 3) == 0)
        wr(3'($urandom_range(0, 7)), N'($urandom));
      else begin
        addr = 3'($urandom_range(0, 7));
        step();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    fails++;
    $display("FAIL watchdog actual=%0d expected<50000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule